// File: doc/BRIEF.md
# Remote Terminal Address Latch Unit

This block owns the 5-bit terminal address of a serial bus remote terminal and the parity bit that goes with it. The value can come from external strap pins or from the host data bus. A latch-control pin picks how it is captured. With the pin low, the stored value tracks the straps. When the pin goes high, the stored value is captured at that edge. While the pin stays high, the only way to capture is a host write to the latch register, and only after two enable bits have been set in other configuration registers.

The host writes configuration through a simple register port. The block keeps only the configuration bits it uses. It drives the stored address and parity to the rest of the terminal. It also checks the address of each incoming command and raises an accept flag when the terminal may answer.

An internal capture state machine has two states. ST_TRACK follows the straps. ST_HOLD keeps the stored value and accepts host captures. It has two transitions. TRACK→HOLD happens when the synchronized latch pin is seen high, and the straps are loaded on that same edge. HOLD→TRACK happens when the synchronized latch pin is seen low.

Top module: `rtaddr_latch_unit`

## Requirements
- R1: After reset, `term_addr` and `term_par` are 0 and all three configuration bits are 0, so the straps are the selected source.
- R2: `addr_ok` is 1 exactly when `term_addr` together with `term_par` holds an odd number of ones.
- R3: With the latch pin low and the source bit at 0, `term_addr`/`term_par` take the strap values present at each rising clock edge.
- R4: After `latch_pin` rises, the strap values present at the third rising clock edge are captured. While the pin stays high, later changes on the straps do not reach `term_addr`/`term_par`.
- R5: While the latch pin is high, a write to register 5 (`wr_sel`=5) leaves the stored value unchanged unless both enable bits were already set before the write. The two enable bits are register 3 bit 15 and register 4 bit 3.
- R6: When the source bit is 1 (register 6 bit 5), an enabled register-5 write stores `wr_data[5:1]` as the address and `wr_data[0]` as the parity.
- R7: When the source bit is 0, an enabled register-5 write stores the strap values and ignores `wr_data[5:0]`.
- R8: A command address of 31 raises `cmd_accept` whatever the stored value and its parity.
- R9: For any other command address, `cmd_accept` is 1 only when that address equals `term_addr` and `addr_ok` is 1.
- R10: With the latch pin low and the source bit at 1, the straps are ignored and the stored value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | External address straps, bit 4 is the MSB |
| strap_par | input | 1 | External parity strap |
| latch_pin | input | 1 | Latch control pin, asynchronous to clk |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register index (3, 4, 5 or 6) |
| wr_data | input | 16 | Host write data |
| cmd_addr | input | 5 | Address field of the incoming command |
| term_addr | output | 5 | Stored terminal address |
| term_par | output | 1 | Stored parity bit |
| addr_ok | output | 1 | Stored address and parity have odd parity |
| cmd_accept | output | 1 | Terminal may answer this command |

## Verification
A wrong capture state shows up on `term_addr` at the first clock edge after the straps change. The stored value either follows straps it should hold, or freezes when it should track. A lost or stray enable bit shows on the next register-5 write, because the stored value then changes or stays put against expectation. A wrong stored value or parity shows at once, through combinational logic, on `addr_ok` and `cmd_accept` for the matching command address.

// File: rtl/rtaddr_pkg.sv
package rtaddr_pkg;
    typedef enum logic [0:0] {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } cap_state_t;

    typedef struct packed {
        logic enh;   // reg 3 bit 15
        logic lat5;  // reg 4 bit 3
        logic src;   // reg 6 bit 5: 1 = host data bus
    } cfg_t;

    localparam int REG_ENH   = 3;
    localparam int REG_LAT5  = 4;
    localparam int REG_CAP   = 5;
    localparam int REG_SRC   = 6;
    localparam int BIT_ENH   = 15;
    localparam int BIT_LAT5  = 3;
    localparam int BIT_SRC   = 5;
endpackage

// File: rtl/rtaddr_sync.sv
module rtaddr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtaddr_cfg_regs.sv
module rtaddr_cfg_regs
    import rtaddr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              cap_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_W'(REG_ENH))  cfg.enh  <= wr_data[BIT_ENH];
            if (wr_sel == SEL_W'(REG_LAT5)) cfg.lat5 <= wr_data[BIT_LAT5];
            if (wr_sel == SEL_W'(REG_SRC))  cfg.src  <= wr_data[BIT_SRC];
        end
    end

    // capture request uses enable bits as they stood before this write
    assign cap_req = wr_en && (wr_sel == SEL_W'(REG_CAP)) && cfg.enh && cfg.lat5;
endmodule

// File: rtl/rtaddr_capture_fsm.sv
module rtaddr_capture_fsm
    import rtaddr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_s,
    input  logic              src_host,
    input  logic              cap_req,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_par,
    input  logic [DATA_W-1:0] wr_data,
    output cap_state_t        state,
    output logic [ADDR_W:0]   stored
);
    cap_state_t       nxt;
    logic             load;
    logic [ADDR_W:0]  load_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_TRACK;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = {strap_addr, strap_par};
        unique case (state)
            ST_TRACK: begin
                load = !src_host;
                nxt  = lat_s ? ST_HOLD : ST_TRACK;
            end
            ST_HOLD: begin
                load = cap_req;
                if (src_host) load_val = wr_data[ADDR_W:0];
                nxt  = lat_s ? ST_HOLD : ST_TRACK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stored <= '0;
        else if (load) stored <= load_val;
    end
endmodule

// File: rtl/rtaddr_cmd_check.sv
module rtaddr_cmd_check #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] term_addr,
    input  logic              term_par,
    output logic              addr_ok,
    output logic              cmd_accept
);
    localparam logic [ADDR_W-1:0] BCAST = '1;

    always_comb begin
        addr_ok    = ^{term_addr, term_par};
        cmd_accept = (cmd_addr == BCAST) || ((cmd_addr == term_addr) && addr_ok);
    end
endmodule

// File: rtl/rtaddr_latch_unit.sv
module rtaddr_latch_unit
    import rtaddr_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_par,
    input  logic              latch_pin,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] term_addr,
    output logic              term_par,
    output logic              addr_ok,
    output logic              cmd_accept
);
    logic            lat_s;
    cfg_t            cfg;
    logic            cap_req;
    cap_state_t      cap_state;
    logic [ADDR_W:0] stored;

    rtaddr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(latch_pin), .q(lat_s)
    );

    rtaddr_cfg_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg(cfg), .cap_req(cap_req)
    );

    rtaddr_capture_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .lat_s(lat_s), .src_host(cfg.src),
        .cap_req(cap_req), .strap_addr(strap_addr), .strap_par(strap_par),
        .wr_data(wr_data), .state(cap_state), .stored(stored)
    );

    assign term_addr = stored[ADDR_W:1];
    assign term_par  = stored[0];

    rtaddr_cmd_check #(.ADDR_W(ADDR_W)) u_chk (
        .cmd_addr(cmd_addr), .term_addr(term_addr), .term_par(term_par),
        .addr_ok(addr_ok), .cmd_accept(cmd_accept)
    );
endmodule

// File: rtl/rtaddr_latch_unit_chk.sv
module rtaddr_latch_unit_chk
    import rtaddr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap_addr,
    input logic              strap_par,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] term_addr,
    input logic              term_par,
    input logic              cmd_accept,
    input cap_state_t        cap_state,
    input logic              src_host,
    input logic              cap_req
);
    localparam logic [ADDR_W-1:0] BCAST = '1;

    p_bad_parity_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_addr != BCAST && (^{term_addr, term_par}) == 1'b0) |-> !cmd_accept);

    p_broadcast_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_addr == BCAST) |-> cmd_accept);

    p_track_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_TRACK && !src_host) |=>
            {term_addr, term_par} == $past({strap_addr, strap_par}));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_HOLD && !cap_req) |=> $stable({term_addr, term_par}));

    p_host_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_HOLD && cap_req && src_host) |=>
            {term_addr, term_par} == $past(wr_data[ADDR_W:0]));

    p_track_host_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == ST_TRACK && src_host) |=> $stable({term_addr, term_par}));
endmodule

bind rtaddr_latch_unit rtaddr_latch_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_par(strap_par),
    .wr_data(wr_data), .cmd_addr(cmd_addr), .term_addr(term_addr),
    .term_par(term_par), .cmd_accept(cmd_accept), .cap_state(cap_state),
    .src_host(cfg.src), .cap_req(cap_req)
);

// File: tb/rtaddr_latch_unit_test.sv
module rtaddr_latch_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] strap_addr = '0;
    logic          strap_par = 1'b0;
    logic          latch_pin = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] term_addr;
    logic          term_par, addr_ok, cmd_accept;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    rtaddr_latch_unit uut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_par(strap_par),
        .latch_pin(latch_pin), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_addr(cmd_addr), .term_addr(term_addr), .term_par(term_par),
        .addr_ok(addr_ok), .cmd_accept(cmd_accept)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
        step();
        wr_en = 1'b0;
    endtask

    function automatic int stored_now();
        return {term_addr, term_par};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hold_val;
        int last_val;
        strap_addr = 5'h15; strap_par = 1'b1;
        repeat (4) step();
        rst_n = 1'b1;
        // R1: reset values before the first edge out of reset
        check("R1 term", stored_now(), 0);
        check("R1 addr_ok", addr_ok, 0);
        cmd_addr = 5'd0; #1;
        check("R1/R9 cmd0 after reset", cmd_accept, 0);

        // R3 and R2: transparent sweep over all strap values
        for (int v = 0; v < 64; v++) begin
            strap_addr = 5'(v >> 1); strap_par = v[0];
            step();
            check("R3 track", stored_now(), v);
            check("R2 parity", addr_ok, $countones(v) % 2);
        end

        // R8 and R9: command sweep against several stored values
        for (int k = 0; k < 4; k++) begin
            int sv;
            sv = (k == 0) ? 6'h0B : (k == 1) ? 6'h0A : (k == 2) ? 6'h3E : 6'h21;
            strap_addr = 5'(sv >> 1); strap_par = sv[0];
            step();
            for (int c = 0; c < 32; c++) begin
                int exp;
                cmd_addr = 5'(c); #1;
                exp = (c == 31) || ((c == (sv >> 1)) && ($countones(sv) % 2 == 1));
                check(c == 31 ? "R8 broadcast" : "R9 match", cmd_accept, exp);
            end
        end

        // R4: rising-edge capture, then strap change ignored
        hold_val = 6'h15;
        strap_addr = 5'(hold_val >> 1); strap_par = hold_val[0];
        latch_pin = 1'b1;
        repeat (4) step();
        strap_addr = 5'h13; strap_par = 1'b0;
        repeat (3) step();
        check("R4 edge capture held", stored_now(), hold_val);

        // R5: register-5 writes without both enables do nothing
        wr(5, 16'h003F); step();
        check("R5 no enables", stored_now(), hold_val);
        wr(3, 16'h8000);
        wr(5, 16'h003F); step();
        check("R5 only enh set", stored_now(), hold_val);

        // R7: enabled capture from straps ignores data
        wr(4, 16'h0008);
        wr(5, 16'h002A); step();
        check("R7 strap capture", stored_now(), 6'h26);

        // R6: host source, all data values
        wr(6, 16'h0020);
        for (int d = 0; d < 64; d++) begin
            wr(5, 16'hFFC0 | d);
            check("R6 host capture", stored_now(), d);
        end
        last_val = 63;

        // R10: latch low with host source ignores straps
        latch_pin = 1'b0;
        strap_addr = 5'h02; strap_par = 1'b1;
        repeat (5) step();
        check("R10 straps ignored", stored_now(), last_val);

        // R3 again after returning source to straps
        wr(6, 16'h0000);
        step();
        check("R3 track resumes", stored_now(), 6'h05);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule